// File: doc/BRIEF.md
# Truncated Phase Accumulator with Spur Classifier

This block is the phase engine of a direct digital synthesizer. Each clock, an A-bit accumulator adds a stored tuning word. The sum wraps modulo 2^A. The upper P bits leave the block as the phase word, which feeds a phase-to-amplitude stage outside this block. The lower B = A−P bits are the truncation word. They are discarded for phase, but they are the source of the periodic phase error that shows up as truncation spurs, so they are also brought out.

A load strobe captures a new tuning word and clears the accumulator. On that same edge the block registers a classification of the word:
- whether its top bit makes it an aliasing (invalid) word;
- whether the truncated field yields no truncation spurs at all;
- whether the truncated field falls in the worst-case class;
- the repetition period of the full accumulator;
- the equivalent tuning word of the truncated field, folded back when it lies above half its range;
- the number of sawtooth harmonics that field produces.

System software or a frequency planner uses these outputs to steer toward clean tuning words.

Top module: `dds_trunc_accum`

## Requirements
- R1: While reset is held, and after it, before any load, every output equals the classification of a zero tuning word: phase_word and trunc_word 0, tune_bad 0, spur_free 1, worst_case 0, period 1, etw 0, harmonics 0.
- R2: On the edge where load is sampled high, the accumulator becomes 0 and the tuning word is captured. On every other non-reset edge the accumulator becomes (accumulator + captured word) mod 2^A, and the carry out of bit A−1 is lost.
- R3: phase_word is accumulator bits [A−1:B] and trunc_word is accumulator bits [B−1:0].
- R4: All classification outputs change only on an edge where load is sampled high. A change on tune_in without load has no effect on any output.
- R5: tune_bad is bit A−1 of the loaded word.
- R6: spur_free is 1 exactly when bits [B−1:0] of the loaded word are all zero, which includes the zero word.
- R7: worst_case is 1 exactly when bits [B−1:0] of the loaded word equal 2^(B−1), that is only bit B−1 set.
- R8: period equals 2^(A−z), where z is the number of trailing zero bits of the loaded word (z = A for zero, giving 1).
- R9: etw is the loaded word mod 2^B. When bit B−1 of that value is 1, etw is 2^B minus that value instead.
- R10: harmonics equals 2^(B−1) / 2^(trailing zeros of etw), and is 0 when etw is 0.
- R11: With A=20, P=8 and the word 182898, period is 524288, etw is 1422 and harmonics is 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture tune_in, clear the accumulator, update the classification |
| tune_in | input | ACC_W | Tuning word offered for loading |
| phase_word | output | PH_W | Upper accumulator bits passed on as phase |
| trunc_word | output | ACC_W−PH_W | Lower accumulator bits discarded for phase |
| tune_bad | output | 1 | Loaded word has its top bit set |
| spur_free | output | 1 | Truncated field of the loaded word is zero |
| worst_case | output | 1 | Truncated field holds only its top bit |
| period | output | ACC_W+1 | Cycles before the accumulator sequence repeats |
| etw | output | ACC_W−PH_W | Alias-folded equivalent word of the truncated field |
| harmonics | output | ACC_W−PH_W | Count of relevant sawtooth harmonics |

## Verification
The hardest cases to reach are the boundaries of the fold. A truncated field of exactly 2^(B−1) folds onto itself and is also the worst case. A field just below or above it must fold differently. The bench loads words that sit on each side of this boundary, and also loads a near-full-scale word whose top bit is set, so the accumulator wraps many times while the model checks that each carry is dropped. It also moves tune_in freely between loads to show that only the strobe reaches the status registers.

// File: rtl/dds_trunc_pkg.sv
package dds_trunc_pkg;

    // Spur class of the truncated field of a tuning word.
    typedef enum logic [1:0] {
        TRC_CLEAN = 2'd0,   // truncated field all zero
        TRC_MIXED = 2'd1,   // between the extremes
        TRC_WORST = 2'd2    // only the top truncated bit set
    } trunc_class_e;

    typedef struct packed {
        logic         bad;  // aliasing word (top bit set)
        trunc_class_e cls;
    } tw_flags_t;

    function automatic trunc_class_e classify(input logic low_zero, input logic half_only);
        trunc_class_e c;
        if (low_zero)       c = TRC_CLEAN;
        else if (half_only) c = TRC_WORST;
        else                c = TRC_MIXED;
        return c;
    endfunction

    localparam tw_flags_t FLAGS_RESET = '{bad: 1'b0, cls: TRC_CLEAN};

endpackage

// File: rtl/tz_count.sv
module tz_count #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    // Scan from the top so the lowest set bit wins; all-zero gives W.
    always_comb begin
        zeros = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) zeros = CW'(i);
        end
    end
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ACC_W-1:0] tune_in,
    output logic [ACC_W-1:0] acc_out
);
    logic [ACC_W-1:0] step_q;

    // Modulo 2^ACC_W: the carry out of the top bit is simply dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= '0;
            step_q  <= '0;
        end else if (load) begin
            acc_out <= '0;
            step_q  <= tune_in;
        end else begin
            acc_out <= acc_out + step_q;
        end
    end
endmodule

// File: rtl/tw_classifier.sv
module tw_classifier
    import dds_trunc_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int TR_W  = 20
) (
    input  logic [ACC_W-1:0] tune_in,
    output tw_flags_t        flags,
    output logic [ACC_W:0]   period
);
    localparam int ZW = $clog2(ACC_W + 1);
    localparam logic [ACC_W:0]  ONE  = 1;
    localparam logic [TR_W-1:0] HALF = {1'b1, {(TR_W-1){1'b0}}};

    logic [ZW-1:0]   tz;
    logic [TR_W-1:0] low;
    int              sh;

    tz_count #(.W(ACC_W)) u_tz (
        .vec   (tune_in),
        .zeros (tz)
    );

    assign low = tune_in[TR_W-1:0];

    always_comb begin
        flags.bad = tune_in[ACC_W-1];
        flags.cls = classify(low == '0, low == HALF);
        // 2^A / gcd(T, 2^A) = 2^(A - trailing zeros of T)
        sh     = ACC_W - int'(tz);
        period = ONE << sh;
    end
endmodule

// File: rtl/alias_fold.sv
module alias_fold #(
    parameter int TR_W = 20
) (
    input  logic [TR_W-1:0] trunc_in,
    output logic [TR_W-1:0] etw,
    output logic [TR_W-1:0] harmonics
);
    localparam int ZW = $clog2(TR_W + 1);
    localparam logic [TR_W-1:0] HALF = {1'b1, {(TR_W-1){1'b0}}};

    logic [ZW-1:0] tz;

    // Upper half of the field aliases: fold to 2^B - value (two's negate).
    always_comb begin
        if (trunc_in[TR_W-1]) etw = (~trunc_in) + 1'b1;
        else                  etw = trunc_in;
    end

    tz_count #(.W(TR_W)) u_tz (
        .vec   (etw),
        .zeros (tz)
    );

    always_comb begin
        if (etw == '0) harmonics = '0;
        else           harmonics = HALF >> tz;
    end
endmodule

// File: rtl/dds_trunc_accum.sv
module dds_trunc_accum
    import dds_trunc_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [ACC_W-1:0]      tune_in,
    output logic [PH_W-1:0]       phase_word,
    output logic [ACC_W-PH_W-1:0] trunc_word,
    output logic                  tune_bad,
    output logic                  spur_free,
    output logic                  worst_case,
    output logic [ACC_W:0]        period,
    output logic [ACC_W-PH_W-1:0] etw,
    output logic [ACC_W-PH_W-1:0] harmonics
);
    localparam int TR_W = ACC_W - PH_W;
    localparam logic [ACC_W:0] ONE = 1;

    logic [ACC_W-1:0] acc;
    tw_flags_t        flags_d, flags_q;
    logic [ACC_W:0]   period_d;
    logic [TR_W-1:0]  etw_d, harm_d;

    phase_accum #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .tune_in (tune_in),
        .acc_out (acc)
    );

    assign phase_word = acc[ACC_W-1:TR_W];
    assign trunc_word = acc[TR_W-1:0];

    tw_classifier #(.ACC_W(ACC_W), .TR_W(TR_W)) u_cls (
        .tune_in (tune_in),
        .flags   (flags_d),
        .period  (period_d)
    );

    alias_fold #(.TR_W(TR_W)) u_fold (
        .trunc_in  (tune_in[TR_W-1:0]),
        .etw       (etw_d),
        .harmonics (harm_d)
    );

    // Status registers: reset state matches a zero tuning word.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= FLAGS_RESET;
            period    <= ONE;
            etw       <= '0;
            harmonics <= '0;
        end else if (load) begin
            flags_q   <= flags_d;
            period    <= period_d;
            etw       <= etw_d;
            harmonics <= harm_d;
        end
    end

    assign tune_bad   = flags_q.bad;
    assign spur_free  = (flags_q.cls == TRC_CLEAN);
    assign worst_case = (flags_q.cls == TRC_WORST);
endmodule

// File: rtl/dds_trunc_accum_chk.sv
module dds_trunc_accum_chk #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  load,
    input logic [ACC_W-1:0]      tune_in,
    input logic [PH_W-1:0]       phase_word,
    input logic [ACC_W-PH_W-1:0] trunc_word,
    input logic                  tune_bad,
    input logic                  spur_free,
    input logic                  worst_case,
    input logic [ACC_W:0]        period,
    input logic [ACC_W-PH_W-1:0] etw,
    input logic [ACC_W-PH_W-1:0] harmonics
);
    localparam int TR_W = ACC_W - PH_W;

    logic [ACC_W-1:0] acc_v;
    assign acc_v = {phase_word, trunc_word};

    p_load_clear_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc_v == '0));

    p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(load) && !$past(rst)) |=>
        ((acc_v - $past(acc_v)) == ($past(acc_v) - $past(acc_v, 2))));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(period) && $stable(etw) && $stable(harmonics) &&
                   $stable(spur_free) && $stable(worst_case) && $stable(tune_bad)));

    p_bad_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (tune_bad == $past(tune_in[ACC_W-1])));

    p_free_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (spur_free == ($past(tune_in[TR_W-1:0]) == '0)));

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(spur_free && worst_case));

    p_period_pow2_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(period) == 1);

    p_harm_pow2_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(harmonics) <= 1);
endmodule

bind dds_trunc_accum dds_trunc_accum_chk #(.ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .tune_in    (tune_in),
    .phase_word (phase_word),
    .trunc_word (trunc_word),
    .tune_bad   (tune_bad),
    .spur_free  (spur_free),
    .worst_case (worst_case),
    .period     (period),
    .etw        (etw),
    .harmonics  (harmonics)
);

// File: tb/tb_dds_trunc_accum.sv
module tb_dds_trunc_accum;
    localparam int A = 20;
    localparam int P = 8;
    localparam int B = A - P;

    typedef struct {
        bit     bad;
        bit     free;
        bit     worst;
        longint per;
        longint etw;
        longint harm;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [A-1:0] tune_in = '0;
    logic [P-1:0] phase_word;
    logic [B-1:0] trunc_word;
    logic         tune_bad, spur_free, worst_case;
    logic [A:0]   period;
    logic [B-1:0] etw, harmonics;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit ended = 1'b0;

    exp_t         q[$];
    exp_t         cur;
    logic [A-1:0] acc_m, tw_m;
    logic         load_d;

    always #10 clk = ~clk;   // 50 MHz

    dds_trunc_accum #(.ACC_W(A), .PH_W(P)) dut (
        .clk(clk), .rst(rst), .load(load), .tune_in(tune_in),
        .phase_word(phase_word), .trunc_word(trunc_word),
        .tune_bad(tune_bad), .spur_free(spur_free), .worst_case(worst_case),
        .period(period), .etw(etw), .harmonics(harmonics)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tzc(longint v, int w);
        for (int i = 0; i < w; i++) if (v[i]) return i;
        return w;
    endfunction

    function automatic exp_t expect_of(longint t);
        exp_t   e;
        longint low;
        low     = t % (64'd1 << B);
        e.bad   = t[A-1];
        e.free  = (low == 0);
        e.worst = (low == (64'd1 << (B - 1)));
        e.per   = 64'd1 << (A - tzc(t, A));
        e.etw   = (low >= (64'd1 << (B - 1))) ? ((64'd1 << B) - low) : low;
        e.harm  = (e.etw == 0) ? 0 : ((64'd1 << (B - 1)) >> tzc(e.etw, B));
        return e;
    endfunction

    // Requirement model of the accumulator (R2): clear on load, else add.
    always @(posedge clk) begin
        if (rst) begin
            acc_m  <= '0;
            tw_m   <= '0;
            load_d <= 1'b0;
        end else begin
            load_d <= load;
            if (load) begin
                acc_m <= '0;
                tw_m  <= tune_in;
            end else begin
                acc_m <= acc_m + tw_m;
            end
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (running && !rst) begin
            if (load_d && q.size() > 0) cur = q.pop_front();
            chk("R2 R3 phase_word", phase_word, acc_m[A-1:B]);
            chk("R2 R3 trunc_word", trunc_word, acc_m[B-1:0]);
            chk("R5 tune_bad", tune_bad, cur.bad);
            chk("R6 spur_free", spur_free, cur.free);
            chk("R7 worst_case", worst_case, cur.worst);
            chk("R8 period", period, cur.per);
            chk("R9 etw", etw, cur.etw);
            chk("R10 harmonics", harmonics, cur.harm);
        end
    end

    task automatic load_word(logic [A-1:0] t, int hold);
        @(negedge clk);
        tune_in = t;
        load    = 1'b1;
        q.push_back(expect_of(t));
        @(negedge clk);
        load = 1'b0;
        repeat (hold) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cur = expect_of(0);
        repeat (3) @(negedge clk);
        // R1: reset state equals the zero-word classification
        chk("R1 phase_word", phase_word, 0);
        chk("R1 trunc_word", trunc_word, 0);
        chk("R1 tune_bad", tune_bad, 0);
        chk("R1 spur_free", spur_free, 1);
        chk("R1 worst_case", worst_case, 0);
        chk("R1 period", period, 1);
        chk("R1 etw", etw, 0);
        chk("R1 harmonics", harmonics, 0);
        rst = 1'b0;
        running = 1'b1;
        repeat (2) @(negedge clk);

        // R11: worked example
        load_word(20'd182898, 20);
        chk("R11 period", period, 524288);
        chk("R11 etw", etw, 1422);
        chk("R11 harmonics", harmonics, 1024);

        load_word(20'd0, 5);            // zero word, R8 period 1
        load_word(20'h00800, 10);       // worst case, folds onto itself
        // R4: tune_in moves without load; nothing may change
        tune_in = 20'h03001;
        repeat (6) @(negedge clk);
        chk("R4 period held", period, 512);
        chk("R4 worst_case held", worst_case, 1);
        chk("R4 etw held", etw, 2048);

        load_word(20'h03000, 8);        // spur free, non-zero
        load_word(20'h80001, 10);       // invalid, odd
        load_word(20'hFFFFF, 30);       // wraps every cycle, R2 carry drop
        load_word(20'h01800, 5);        // worst case with phase bits
        load_word(20'h007FF, 10);       // just below fold boundary
        load_word(20'h00801, 10);       // just above fold boundary
        load_word(20'h40000, 5);        // spur free, short period
        load_word(20'd182898, 3);       // reload mid-run clears accumulator
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule